// File: doc/BRIEF.md
# Subtraction-Based Magnitude Comparator

This block compares two equal-width operands, `a` and `b`, and raises exactly one of three relation outputs: `a` greater than `b`, `a` less than `b`, or the two equal. A single mode input decides whether the operands are read as unsigned integers or as two's-complement signed integers. The block is purely combinational. The outputs follow the operands within the same cycle and hold no state.

Internally the block forms the difference `b - a` as `b + ~a + 1`. A log-depth parallel-prefix adder does the sum, and the forced carry-in supplies the `+1`. A zero detector on the difference marks equality. In unsigned mode the adder's carry-out decides the ordering. In signed mode the most significant bit of the difference is first corrected for two's-complement overflow, and the corrected sign then decides the ordering. The operand width is a parameter.

Top module: `cmp_mag_compare`

## Requirements
- R1: `a_eq_b` is 1 exactly when `a` and `b` are bit-for-bit identical, in both modes.
- R2: With `mode_signed` = 0 (unsigned), `a_gt_b` is 1 exactly when `a` is greater than `b` as an unsigned integer. An adder carry-out of 0 from `b + ~a + 1` means `a > b`.
- R3: With `mode_signed` = 0, `a_lt_b` is 1 exactly when `a` is less than `b` as an unsigned integer. This is the case where the carry-out is 1 and the difference is nonzero.
- R4: With `mode_signed` = 1 (two's complement, bit W-1 is the sign), `a_gt_b` is 1 exactly when `a` is greater than `b` as a signed integer. This includes mixed-sign pairs whose difference overflows.
- R5: With `mode_signed` = 1, `a_lt_b` is 1 exactly when `a` is less than `b` as a signed integer.
- R6: For every operand pair and every mode, exactly one of `a_gt_b`, `a_lt_b` and `a_eq_b` is 1.
- R7: The mode input alone can reverse the ordering. When the operands differ in bit W-1, the unsigned and signed results are opposite. For example, with `a` = 16'h8000 and `b` = 16'h0001, unsigned mode gives `a_gt_b` and signed mode gives `a_lt_b`.
- R8: The outputs are combinational. A new operand pair or mode shows its result without any clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| mode_signed | input | 1 | 0 = unsigned comparison, 1 = two's-complement comparison |
| a_gt_b | output | 1 | `a` is greater than `b` |
| a_lt_b | output | 1 | `a` is less than `b` |
| a_eq_b | output | 1 | `a` equals `b` |

## Verification
Immediate assertions inside the RTL check three things whenever the inputs change: the prefix adder's sum and carry against a plain arithmetic sum, one-hot outputs, and agreement of each relation with a relational operator in the selected mode. Some behaviour only the bench scenarios can show. The sign-correction path must be driven with the extreme pairs (most negative against most positive, and mixed-sign pairs that overflow). The mode flip on operands whose top bits differ, and the same-cycle response without a clock edge, also rest on those directed scenarios.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef enum logic {
        CMP_UNSIGNED = 1'b0,
        CMP_SIGNED   = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic carry;
        logic neg;
        logic ovf;
        logic zero;
    } cmp_flags_t;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } cmp_rel_t;

    // Prefix combine of a higher (hi) span with the adjacent lower (lo) span.
    // Result bit 1 is group generate, bit 0 is group propagate.
    function automatic logic [1:0] pg_merge(input logic hi_g, input logic hi_p,
                                            input logic lo_g, input logic lo_p);
        return {hi_g | (hi_p & lo_g), hi_p & lo_p};
    endfunction

endpackage

// File: rtl/cmp_prefix_adder.sv
module cmp_prefix_adder
    import cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int LEVELS = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0] half_sum;
    logic [W-1:0] grp_g;
    logic [W-1:0] grp_p;
    logic [W-1:0] nxt_g;
    logic [W-1:0] nxt_p;
    logic [W-1:0] carry_vec;

    // Kogge-Stone network: span doubles on each level, fanout stays two.
    always_comb begin
        half_sum = x ^ y;
        grp_g    = x & y;
        grp_p    = half_sum;
        // Carry-in folded into bit 0 so every group generate includes it.
        grp_g[0] = grp_g[0] | (half_sum[0] & cin);
        for (int lvl = 0; lvl < LEVELS; lvl++) begin
            nxt_g = grp_g;
            nxt_p = grp_p;
            for (int i = 0; i < W; i++) begin
                if (i >= (1 << lvl)) begin
                    {nxt_g[i], nxt_p[i]} = pg_merge(grp_g[i], grp_p[i],
                                                    grp_g[i - (1 << lvl)],
                                                    grp_p[i - (1 << lvl)]);
                end
            end
            grp_g = nxt_g;
            grp_p = nxt_p;
        end
        carry_vec[0] = cin;
        for (int i = 1; i < W; i++) begin
            carry_vec[i] = grp_g[i-1];
        end
        sum  = half_sum ^ carry_vec;
        cout = grp_g[W-1];
    end

    // R2 / R3 rest on a correct sum and carry-out from the prefix network.
    always_comb begin
        assert_adder_sum_R2: assert ({cout, sum} ==
                ({1'b0, x} + {1'b0, y} + (W+1)'(cin)))
            else $error("prefix adder sum mismatch");
    end

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
    import cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] diff,
    input  logic         carry_out,
    input  logic         a_sign,
    input  logic         b_sign,
    output cmp_flags_t   flags
);
    always_comb begin
        flags.carry = carry_out;
        flags.zero  = ~|diff;
        flags.neg   = diff[W-1];
        // Overflow: operands of opposite sign and a result sign unlike b's.
        flags.ovf   = (a_sign ^ b_sign) & (diff[W-1] ^ b_sign);
    end

endmodule

// File: rtl/cmp_rel_decode.sv
module cmp_rel_decode
    import cmp_pkg::*;
(
    input  cmp_flags_t flags,
    input  cmp_mode_e  mode,
    output cmp_rel_t   rel
);
    logic true_sign;

    always_comb begin
        true_sign = flags.neg ^ flags.ovf;
        rel.eq    = flags.zero;
        if (mode == CMP_SIGNED) begin
            rel.gt = true_sign;
            rel.lt = ~true_sign & ~flags.zero;
        end else begin
            rel.gt = ~flags.carry;
            rel.lt = flags.carry & ~flags.zero;
        end
    end

    // R6: the three relations never overlap and never all drop.
    always_comb begin
        assert_one_hot_R6: assert ($onehot({rel.gt, rel.lt, rel.eq}))
            else $error("relation outputs not one-hot");
    end

endmodule

// File: rtl/cmp_mag_compare.sv
module cmp_mag_compare
    import cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         mode_signed,
    output logic         a_gt_b,
    output logic         a_lt_b,
    output logic         a_eq_b
);
    logic [W-1:0] diff;
    logic         carry_out;
    cmp_flags_t   flags;
    cmp_rel_t     rel;
    cmp_mode_e    mode;

    assign mode = cmp_mode_e'(mode_signed);

    // b - a = b + ~a + 1, the +1 entering as carry-in.
    cmp_prefix_adder #(.W(W)) u_adder (
        .x    (b),
        .y    (~a),
        .cin  (1'b1),
        .sum  (diff),
        .cout (carry_out)
    );

    cmp_flag_unit #(.W(W)) u_flags (
        .diff      (diff),
        .carry_out (carry_out),
        .a_sign    (a[W-1]),
        .b_sign    (b[W-1]),
        .flags     (flags)
    );

    cmp_rel_decode u_decode (
        .flags (flags),
        .mode  (mode),
        .rel   (rel)
    );

    assign a_gt_b = rel.gt;
    assign a_lt_b = rel.lt;
    assign a_eq_b = rel.eq;

    always_comb begin
        assert_equal_R1: assert (a_eq_b == (a == b))
            else $error("equality output wrong");
        if (mode_signed) begin
            assert_signed_gt_R4: assert (a_gt_b == ($signed(a) > $signed(b)))
                else $error("signed greater-than wrong");
            assert_signed_lt_R5: assert (a_lt_b == ($signed(a) < $signed(b)))
                else $error("signed less-than wrong");
        end else begin
            assert_unsigned_gt_R2: assert (a_gt_b == (a > b))
                else $error("unsigned greater-than wrong");
            assert_unsigned_lt_R3: assert (a_lt_b == (a < b))
                else $error("unsigned less-than wrong");
        end
    end

endmodule

// File: tb/cmp_mag_compare_tb.sv
module cmp_mag_compare_tb;
    localparam int W = 16;
    localparam int TIMEOUT_CYCLES = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         mode_signed = 1'b0;
    logic         a_gt_b, a_lt_b, a_eq_b;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cmp_mag_compare #(.W(W)) u_dut (
        .a           (a),
        .b           (b),
        .mode_signed (mode_signed),
        .a_gt_b      (a_gt_b),
        .a_lt_b      (a_lt_b),
        .a_eq_b      (a_eq_b)
    );

    task automatic check_bit(input string req, input string what,
                             input logic got, input logic exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: a=%h b=%h mode=%0d got=%0b exp=%0b",
                     req, what, a, b, mode_signed, got, exp);
        end
    endtask

    // Behavioural reference using integer arithmetic only.
    task automatic compare_now();
        longint ua, ub, sa, sb;
        logic e_gt, e_lt, e_eq;
        ua = longint'(a);
        ub = longint'(b);
        sa = a[W-1] ? ua - (longint'(1) << W) : ua;
        sb = b[W-1] ? ub - (longint'(1) << W) : ub;
        if (mode_signed) begin
            e_gt = sa > sb; e_lt = sa < sb;
        end else begin
            e_gt = ua > ub; e_lt = ua < ub;
        end
        e_eq = (ua == ub);
        check_bit("R1", "eq", a_eq_b, e_eq);
        check_bit(mode_signed ? "R4" : "R2", "gt", a_gt_b, e_gt);
        check_bit(mode_signed ? "R5" : "R3", "lt", a_lt_b, e_lt);
        check_bit("R6", "onehot", logic'($countones({a_gt_b, a_lt_b, a_eq_b}) == 1), 1'b1);
    endtask

    // Drive on the falling edge, compare a little later in the same cycle.
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic m);
        @(negedge clk);
        a = va; b = vb; mode_signed = m;
        #2;
        compare_now();
    endtask

    initial begin
        repeat (TIMEOUT_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #2;
        // Reset state: zero operands read as equal.
        check_bit("R1", "reset eq", a_eq_b, 1'b1);

        for (int m = 0; m < 2; m++) begin
            apply(16'h0000, 16'h0000, logic'(m));
            apply(16'hFFFF, 16'hFFFF, logic'(m));
            apply(16'h8000, 16'h7FFF, logic'(m));   // most negative vs most positive
            apply(16'h7FFF, 16'h8000, logic'(m));
            apply(16'h8000, 16'h8000, logic'(m));
            apply(16'h7FFF, 16'h7FFF, logic'(m));
            apply(16'h8000, 16'h0001, logic'(m));   // mixed sign, overflowing difference
            apply(16'h0001, 16'h8000, logic'(m));
            apply(16'hC000, 16'h4000, logic'(m));
            apply(16'h4000, 16'hC000, logic'(m));
            apply(16'hFFFF, 16'h0000, logic'(m));
            apply(16'h0000, 16'hFFFF, logic'(m));
            apply(16'h1234, 16'h1235, logic'(m));
            apply(16'h1235, 16'h1234, logic'(m));
        end

        // R7: mode alone flips the ordering when top bits differ.
        apply(16'h8000, 16'h0001, 1'b0);
        check_bit("R7", "unsigned gt", a_gt_b, 1'b1);
        apply(16'h8000, 16'h0001, 1'b1);
        check_bit("R7", "signed lt", a_lt_b, 1'b1);

        // R8: change inputs mid-cycle with no clock edge in between.
        @(posedge clk);
        #3;
        a = 16'h0005; b = 16'h0009; mode_signed = 1'b0;
        #1;
        check_bit("R8", "lt same cycle", a_lt_b, 1'b1);
        a = 16'h0009;
        #1;
        check_bit("R8", "eq same cycle", a_eq_b, 1'b1);
        a = 16'hFFF0;
        mode_signed = 1'b1;
        #1;
        check_bit("R8", "signed lt same cycle", a_lt_b, 1'b1);

        // Spread of pseudo-random pairs, one per clock.
        for (int k = 0; k < 4000; k++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = (k % 7 == 0) ? ra : W'($urandom);
            apply(ra, rb, logic'(k % 2));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule